// File: doc/BRIEF.md
# Search Pass Sequencer for a Single-Wire Bus Master

This block carries out one complete pass of the identity search on a single-wire, open-drain bus without the host touching individual bits. The host has already sent a bus reset and the search command byte. It then turns on the search enable and streams in sixteen bytes. For every one of the 64 identity positions the block asks a bit-slot timing engine for two read slots and then one write slot. It chooses the written value from the two read results and a preference bit taken from the host byte.

Each input byte covers four consecutive positions. After those four positions the block emits one result byte. The result byte holds, for each position, the path bit that was written and a flag marking a discrepancy. Both streams use valid/ready. An input byte is accepted only when the result buffer is empty. A result byte, once valid, stays valid with unchanged data until the host takes it. While a result waits, no new input is taken and no slot is requested, so back-pressure on the output stalls the whole pass. Lowering the enable aborts the pass and returns the block to its start state.

Top module: `ow_srch_accel`

## Requirements
- R1: For each position the block issues exactly three slot requests, in the order read, read, write. A read request has `slot_req_write`=0 and `slot_req_bit`=1. While a request waits for `slot_req_ready`, its write flag and bit stay unchanged.
- R2: Let the first read be b0 and the second read be b1. The written bit is b0 when b0≠b1. It is 1 when b0=b1=1. It is the host preference bit when b0=b1=0.
- R3: The discrepancy flag of a position is 1 when b0=b1 and 0 when b0≠b1.
- R4: Input byte j (j = 0..15, in arrival order) covers positions 4j..4j+3. The preference bit for position 4j+k sits at bit 2k+1. Bits 0, 2, 4 and 6 are ignored.
- R5: Output byte j carries the discrepancy flag of position 4j+k at bit 2k and the written bit of that position at bit 2k+1.
- R6: Once a position has read b0=b1=1, every later position of the same pass writes 1 and reports path 1 with discrepancy 1. This holds until the enable is lowered.
- R7: `in_ready` is high only while no result byte is pending. A pending result keeps `out_valid` high and `out_data` stable until `out_ready`. No slot is requested while a result is pending.
- R8: After the sixteenth result byte, the block accepts no more input while the enable stays high. Lowering and raising the enable starts a fresh pass with the error state cleared.
- R9: While the enable is low or reset is asserted, `in_ready`, `out_valid` and `slot_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srch_en | input | 1 | Search mode enable; low aborts and clears |
| in_valid | input | 1 | Host preference byte valid |
| in_ready | output | 1 | Preference byte accepted this cycle when valid |
| in_data | input | 8 | Interleaved preference byte |
| out_valid | output | 1 | Result byte valid |
| out_ready | input | 1 | Host takes the result byte |
| out_data | output | 8 | Interleaved result byte (flags even, path odd) |
| slot_req_valid | output | 1 | Slot request to the timing engine |
| slot_req_ready | input | 1 | Timing engine accepts the request |
| slot_req_write | output | 1 | 1 = write slot, 0 = read slot |
| slot_req_bit | output | 1 | Value driven in the slot (1 for reads) |
| slot_rsp_valid | input | 1 | Slot finished, one-cycle pulse |
| slot_rsp_bit | input | 1 | Bus value sampled in the finished slot |

## Verification
A bench model of the bus holds up to four devices and wired-ANDs their identity bits. This lets each pass produce a known mix of agreeing, differing and empty read pairs.

- A single device gives only differing pairs, which isolates the copy-b0 choice.
- Several devices with all preferences 0 and then all 1 exercise the conflict rule. They separate the preference bit from b0. With the even filler bits set, they also show that those bits are ignored.
- An empty bus gives all-ones read pairs from the first position onward.
- A one-position forced no-response, with the device still present, shows that later positions are forced to 1/1 even though their natural reads differ.
- Holding `out_ready` low shows that the whole pass stalls.

// File: rtl/ow_srch_pkg.sv
package ow_srch_pkg;
  typedef enum logic [2:0] {
    ST_LOAD,
    ST_RD0,
    ST_WT0,
    ST_RD1,
    ST_WT1,
    ST_WR,
    ST_WTW,
    ST_DONE
  } srch_state_e;
endpackage

// File: rtl/ow_srch_decide.sv
// Per-position choice of the written bit and the discrepancy flag.
module ow_srch_decide (
  input  logic b0,
  input  logic b1,
  input  logic pref,
  input  logic err_in,
  output logic wbit,
  output logic disc,
  output logic err_out
);
  logic no_rsp;
  logic agree;

  always_comb begin
    no_rsp  = b0 & b1;
    agree   = ~(b0 ^ b1);
    err_out = err_in | no_rsp;
    if (err_in || no_rsp) begin
      wbit = 1'b1;
    end else if (agree) begin
      wbit = pref;
    end else begin
      wbit = b0;
    end
    disc = err_in | agree;
  end
endmodule

// File: rtl/ow_srch_obuf.sv
// One-entry result holding register with valid/ready output.
module ow_srch_obuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (clr) begin
      out_valid <= 1'b0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_data  <= push_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ow_srch_accel.sv
module ow_srch_accel
  import ow_srch_pkg::*;
#(
  parameter int ID_BITS = 64,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srch_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              slot_req_valid,
  input  logic              slot_req_ready,
  output logic              slot_req_write,
  output logic              slot_req_bit,
  input  logic              slot_rsp_valid,
  input  logic              slot_rsp_bit
);
  localparam int POS_PER_BYTE = BYTE_W / 2;
  localparam int N_BYTES      = ID_BITS / POS_PER_BYTE;
  localparam int POS_W        = (POS_PER_BYTE > 1) ? $clog2(POS_PER_BYTE) : 1;
  localparam int CNT_W        = $clog2(N_BYTES + 1);

  srch_state_e       state_q;
  logic [BYTE_W-1:0] pref_q;
  logic [BYTE_W-1:0] acc_q;
  logic [BYTE_W-1:0] acc_nx;
  logic [POS_W-1:0]  pos_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              b0_q, b1_q, err_q;
  logic              pref_bit, wbit, disc, err_nx;
  logic              obuf_empty, push, last_pos, last_byte;
  logic [POS_W:0]    idx_path, idx_disc;

  assign idx_path  = {pos_q, 1'b1};
  assign idx_disc  = {pos_q, 1'b0};
  assign pref_bit  = pref_q[idx_path];
  assign last_pos  = (pos_q == POS_W'(POS_PER_BYTE - 1));
  assign last_byte = (cnt_q == CNT_W'(N_BYTES - 1));

  ow_srch_decide u_decide (
    .b0     (b0_q),
    .b1     (b1_q),
    .pref   (pref_bit),
    .err_in (err_q),
    .wbit   (wbit),
    .disc   (disc),
    .err_out(err_nx)
  );

  always_comb begin
    acc_nx           = acc_q;
    acc_nx[idx_disc] = disc;
    acc_nx[idx_path] = wbit;
  end

  assign push = srch_en && (state_q == ST_WTW) && slot_rsp_valid && last_pos;

  ow_srch_obuf #(.W(BYTE_W)) u_obuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!srch_en),
    .push     (push),
    .push_data(acc_nx),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );

  assign obuf_empty     = !out_valid;
  assign in_ready       = srch_en && (state_q == ST_LOAD) && obuf_empty;
  assign slot_req_valid = (state_q == ST_RD0) || (state_q == ST_RD1) || (state_q == ST_WR);
  assign slot_req_write = (state_q == ST_WR);
  assign slot_req_bit   = (state_q == ST_WR) ? wbit : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOAD;
      pref_q  <= '0;
      acc_q   <= '0;
      pos_q   <= '0;
      cnt_q   <= '0;
      b0_q    <= 1'b0;
      b1_q    <= 1'b0;
      err_q   <= 1'b0;
    end else if (!srch_en) begin
      state_q <= ST_LOAD;
      acc_q   <= '0;
      pos_q   <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_LOAD: if (in_valid && in_ready) begin
          pref_q  <= in_data;
          acc_q   <= '0;
          pos_q   <= '0;
          state_q <= ST_RD0;
        end
        ST_RD0: if (slot_req_ready) state_q <= ST_WT0;
        ST_WT0: if (slot_rsp_valid) begin
          b0_q    <= slot_rsp_bit;
          state_q <= ST_RD1;
        end
        ST_RD1: if (slot_req_ready) state_q <= ST_WT1;
        ST_WT1: if (slot_rsp_valid) begin
          b1_q    <= slot_rsp_bit;
          state_q <= ST_WR;
        end
        ST_WR:  if (slot_req_ready) state_q <= ST_WTW;
        ST_WTW: if (slot_rsp_valid) begin
          acc_q <= acc_nx;
          err_q <= err_nx;
          if (last_pos) begin
            cnt_q   <= cnt_q + 1'b1;
            state_q <= last_byte ? ST_DONE : ST_LOAD;
          end else begin
            pos_q   <= pos_q + 1'b1;
            state_q <= ST_RD0;
          end
        end
        ST_DONE: state_q <= ST_DONE;
        default: state_q <= ST_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/ow_srch_accel_chk.sv
module ow_srch_accel_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              srch_en,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_data,
  input logic              slot_req_valid,
  input logic              slot_req_ready,
  input logic              slot_req_write,
  input logic              slot_req_bit
);
  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req_valid && !slot_req_ready && srch_en |=>
      slot_req_valid && $stable(slot_req_write) && $stable(slot_req_bit));

  p_read_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req_valid && !slot_req_write |-> slot_req_bit);

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && srch_en |=> out_valid && $stable(out_data));

  p_no_req_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !slot_req_valid);

  p_in_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_en |=> !slot_req_valid && !out_valid);

  p_off_no_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_en |-> !in_ready);
endmodule

bind ow_srch_accel ow_srch_accel_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .srch_en       (srch_en),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .slot_req_valid(slot_req_valid),
  .slot_req_ready(slot_req_ready),
  .slot_req_write(slot_req_write),
  .slot_req_bit  (slot_req_bit)
);

// File: tb/test_ow_srch_accel.sv
`timescale 1ns/1ps
module test_ow_srch_accel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic srch_en = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_data;
  logic slot_req_valid, slot_req_write, slot_req_bit;
  logic slot_req_ready = 1'b1;
  logic slot_rsp_valid = 1'b0;
  logic slot_rsp_bit = 1'b0;

  always #2.5 clk = ~clk;

  ow_srch_accel i_ow_srch_accel (
    .clk(clk), .rst_n(rst_n), .srch_en(srch_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .slot_req_valid(slot_req_valid), .slot_req_ready(slot_req_ready),
    .slot_req_write(slot_req_write), .slot_req_bit(slot_req_bit),
    .slot_rsp_valid(slot_rsp_valid), .slot_rsp_bit(slot_rsp_bit)
  );

  int checks = 0;
  int errors = 0;

  // bus model state
  logic [63:0] rom [4];
  int          ndev = 0;
  logic [3:0]  active;
  int          glitch = -1;
  int          epos, ereads, proto_err, req_cnt;
  logic [63:0] wr_bits;
  logic [63:0] exp_path, exp_disc;
  logic [63:0] got_path, got_disc;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic bus_and(input int pos, input bit second, input logic [3:0] act);
    logic r = 1'b1;
    for (int d = 0; d < ndev; d++)
      if (act[d]) r &= second ? ~rom[d][pos] : rom[d][pos];
    return r;
  endfunction

  // timing engine + wired-AND bus model
  logic pend_bit;
  bit   hs = 0;
  int   cnt = 0;
  initial begin
    forever begin
      @(negedge clk);
      slot_rsp_valid = 1'b0;
      if (hs) begin
        hs = 0;
        slot_req_ready = 1'b0;
        cnt = 2;
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          slot_rsp_valid = 1'b1;
          slot_rsp_bit   = pend_bit;
          slot_req_ready = 1'b1;
        end
      end else if (slot_req_valid && slot_req_ready) begin
        hs = 1;
        req_cnt++;
        if (epos > 63) begin
          proto_err++;
          pend_bit = 1'b1;
        end else if (slot_req_write) begin
          if (ereads != 2) proto_err++;
          wr_bits[epos] = slot_req_bit;
          for (int d = 0; d < ndev; d++)
            if (active[d] && rom[d][epos] != slot_req_bit) active[d] = 1'b0;
          pend_bit = slot_req_bit;
          epos++;
          ereads = 0;
        end else begin
          if (ereads >= 2 || !slot_req_bit) proto_err++;
          pend_bit = (epos == glitch) ? 1'b1 : bus_and(epos, ereads == 1, active);
          ereads++;
        end
      end
    end
  end

  // expected results straight from the selection rules
  task automatic expect_pass(input logic [63:0] prefs);
    logic [3:0] act = '1;
    logic err = 1'b0;
    for (int n = 0; n < 64; n++) begin
      logic b0, b1, w;
      b0 = (n == glitch) ? 1'b1 : bus_and(n, 1'b0, act);
      b1 = (n == glitch) ? 1'b1 : bus_and(n, 1'b1, act);
      if (b0 && b1) err = 1'b1;
      if (err) w = 1'b1;
      else if (b0 != b1) w = b0;
      else w = prefs[n];
      exp_path[n] = w;
      exp_disc[n] = err | (b0 == b1);
      for (int d = 0; d < ndev; d++)
        if (act[d] && rom[d][n] != w) act[d] = 1'b0;
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_pass(input logic [63:0] prefs, input logic [7:0] fill,
                          input int stall, input string req);
    @(negedge clk);
    srch_en = 1'b0;
    @(negedge clk);
    active = '1; epos = 0; ereads = 0; proto_err = 0; wr_bits = '0;
    srch_en = 1'b1;
    expect_pass(prefs);
    for (int j = 0; j < 16; j++) begin
      logic [7:0] b, eb;
      b = fill & 8'h55;
      for (int k = 0; k < 4; k++) begin
        b[2*k+1]  = prefs[4*j+k];
        eb[2*k]   = exp_disc[4*j+k];
        eb[2*k+1] = exp_path[4*j+k];
      end
      push_byte(b);
      while (!out_valid) @(negedge clk);
      if (stall > 0 && j == 5) begin
        logic [7:0] held = out_data;
        int rc = req_cnt;
        bit ok = 1;
        in_valid = 1'b1;
        in_data  = 8'hAA;
        repeat (stall) begin
          @(negedge clk);
          if (!out_valid || out_data != held || in_ready || slot_req_valid || req_cnt != rc) ok = 0;
        end
        in_valid = 1'b0;
        chk(ok, "R7 stall", {56'd0, out_data}, {56'd0, held});
      end
      chk(out_data == eb, req, {56'd0, out_data}, {56'd0, eb});
      for (int k = 0; k < 4; k++) begin
        got_disc[4*j+k] = out_data[2*k];
        got_path[4*j+k] = out_data[2*k+1];
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    repeat (4) @(negedge clk);
    chk(wr_bits == got_path, "R5 written bit equals reported path", got_path, wr_bits);
    chk(proto_err == 0 && epos == 64, "R1 read-read-write per position",
        64'(proto_err), 64'd0);
  endtask

  task automatic t_reset();
    chk(!in_ready && !out_valid && !slot_req_valid, "R9 reset quiet",
        {61'd0, in_ready, out_valid, slot_req_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!in_ready && !slot_req_valid, "R9 enable low quiet",
        {62'd0, in_ready, slot_req_valid}, 64'd0);
  endtask

  task automatic t_single();
    ndev = 1; rom[0] = 64'hC3A5_0F96_1E2D_7B48; glitch = -1;
    run_pass(64'd0, 8'h00, 0, "R2 R5 single device differing reads");
    chk(got_path == rom[0] && got_disc == 64'd0, "R2 path equals id", got_path, rom[0]);
  endtask

  task automatic t_multi();
    ndev = 4; glitch = -1;
    rom[0] = 64'h1234_5678_9ABC_DEF0;
    rom[1] = 64'h1234_5678_9ABC_DEF5;
    rom[2] = 64'h8234_5678_9ABC_DEF1;
    rom[3] = 64'h0F0F_F0F0_3C3C_C3CA;
    run_pass(64'd0, 8'h00, 0, "R3 conflicts preference 0");
    run_pass(64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 0, "R4 conflicts preference 1 even bits set");
    run_pass(64'h0000_0000_0000_0005, 8'h55, 0, "R2 R4 mixed preferences");
  endtask

  task automatic t_empty();
    ndev = 0; glitch = -1;
    run_pass(64'd0, 8'h00, 0, "R6 empty bus");
    chk(got_path == '1 && got_disc == '1, "R6 all ones", got_path, '1);
  endtask

  task automatic t_glitch();
    ndev = 1; rom[0] = 64'h0000_0000_0000_0400; glitch = 10;
    run_pass(64'd0, 8'h00, 0, "R6 error forces later positions");
    chk(got_disc[63] && got_path[63] && got_path[9:0] == 10'd0, "R6 last position 1/1",
        {got_path[63], got_disc[63]}, 64'd3);
    glitch = -1;
    run_pass(64'd0, 8'h00, 0, "R8 error cleared after re-enable");
  endtask

  task automatic t_stall();
    ndev = 2; glitch = -1;
    rom[0] = 64'hDEAD_BEEF_0000_1111;
    rom[1] = 64'hDEAD_BEEF_0000_1113;
    run_pass(64'd0, 8'h00, 20, "R7 result after back-pressure");
  endtask

  task automatic t_done();
    bit ok = 1;
    int rc = req_cnt;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h00;
    repeat (12) begin
      @(negedge clk);
      if (in_ready || slot_req_valid || out_valid) ok = 0;
    end
    chk(ok && req_cnt == rc, "R8 no input after sixteenth byte", 64'(req_cnt - rc), 64'd0);
    srch_en = 1'b0;
    @(negedge clk);
    chk(!in_ready, "R9 enable low blocks input", {63'd0, in_ready}, 64'd0);
    in_valid = 1'b0;
    srch_en  = 1'b1;
    @(negedge clk);
    chk(in_ready, "R8 fresh pass after re-enable", {63'd0, in_ready}, 64'd1);
    srch_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    epos = 0; ereads = 0; proto_err = 0; req_cnt = 0; active = '1; wr_bits = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_empty();
    t_glitch();
    t_stall();
    t_done();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule